// File: doc/BRIEF.md
# Masked Step Sequencer

This block walks through a small on-chip table of output words, one step for each false-to-true transition of its advance condition. The word at the current step is merged into a registered output bus through a per-bit output mask. Bits whose mask bit is clear keep their previous value, so several sequencers or other logic can share one set of output devices. Each bit of a table word controls one output device.

The same table entry also acts as a reference pattern. A compare path masks the live input image and the reference with a compare mask and raises a match flag when they agree. A capture path writes the live input image into the entry at the current step, so a reference table can be recorded by stepping a machine through its cycle by hand. The table is loaded through a synchronous write port, which wins over a capture in the same cycle. A length register sets the last step. After the last step the position returns to step 1 and a one-cycle done pulse marks the wrap. Step 0 is the reset position and is never revisited.

Top module: `step_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the position to 0, the output word to 0 and the done pulse, and sets the length register to DEPTH-1. The advance condition is treated as already true after reset, so a condition held high through reset does not advance the position.
- R2: The position changes only at a clock edge where adv_cond is 1 and was 0 at the previous edge. When it is below the length register, it then increases by exactly one. Holding adv_cond high for more cycles does not move it again.
- R3: On an advance where the position is greater than or equal to the length register, the position becomes 1 and done_pulse is 1 for exactly the following cycle. At all other times done_pulse is 0.
- R4: While the position is nonzero, at each clock edge every output bit with out_mask bit 1 takes the corresponding bit of the table entry at the current position, and every bit with mask bit 0 keeps its value. While the position is 0 the output word holds.
- R5: With the default combinational variant, cmp_match is 1 exactly when the position is nonzero and (in_image AND cmp_mask) equals (table entry at the position AND cmp_mask).
- R6: With load_req 1 and tbl_we 0 at a clock edge, in_image is written into the table entry at the current position and is used from the next edge onward.
- R7: With tbl_we 1 at a clock edge, tbl_wdata is written to entry tbl_addr and any load_req in that cycle is dropped.
- R8: With len_we 1 at a clock edge, the length register takes len_in; a value of 0 is stored as 1, and a value above DEPTH-1 is stored as DEPTH-1. A length below the current position makes the next advance wrap (R3).
- R9: Once the position has left step 0 it never returns to 0 except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_cond | input | 1 | Advance condition; a false-to-true transition moves one step |
| len_we | input | 1 | Length register write enable |
| len_in | input | ADDR_W | New last-step number |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | ADDR_W | Table entry to write |
| tbl_wdata | input | WORD_W | Table write data |
| load_req | input | 1 | Capture in_image into the entry at the current step |
| in_image | input | WORD_W | Live input image |
| out_mask | input | WORD_W | Per-bit output update mask (1 = update) |
| cmp_mask | input | WORD_W | Per-bit compare mask (1 = compared) |
| out_word | output | WORD_W | Registered masked output word |
| cmp_match | output | 1 | Masked input image equals the current reference |
| step_pos | output | ADDR_W | Current step, 0 after reset |
| done_pulse | output | 1 | One-cycle pulse after a wrap to step 1 |

## Verification
The hardest situations to reach are those where two paths meet in the same cycle. A table write and a capture can coincide while the position points at the capture entry. A length write can drop below the current position just before an advance. To reach them, the bench first walks the position to a known step. It then issues the write and the capture together, aimed at the neighbouring entry, and watches the output word at the current step stay unchanged. It then lowers the length under the position and checks that the next advance wraps with a done pulse. A condition held high across reset release is also driven, to show that no step is taken.

// File: rtl/seq_pkg.sv
package seq_pkg;

   // action chosen by the step counter for one clock edge
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_NEXT = 2'd1,
      STEP_WRAP = 2'd2
   } step_act_e;

   // first step of the working cycle (step 0 is the reset step)
   localparam int unsigned FIRST_STEP = 1;

endpackage

// File: rtl/seq_rise_detect.sv
module seq_rise_detect #(
   parameter bit IDLE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic rise,
   output logic level_q
);

   always_ff @(posedge clk) begin
      if (rst) level_q <= IDLE_HIGH;
      else     level_q <= level;
   end

   assign rise = level & ~level_q;

endmodule

// File: rtl/seq_step_counter.sv
module seq_step_counter
   import seq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              advance,
   input  logic              len_we,
   input  logic [ADDR_W-1:0] len_in,
   output logic [ADDR_W-1:0] pos,
   output logic [ADDR_W-1:0] len_q,
   output logic              wrap_pulse
);

   localparam logic [ADDR_W-1:0] LAST_STEP  = ADDR_W'(DEPTH - 1);
   localparam logic [ADDR_W-1:0] START_STEP = ADDR_W'(FIRST_STEP);
   localparam bool_full = (DEPTH == (1 << ADDR_W));

   step_act_e          act;
   logic [ADDR_W-1:0]  len_fix;

   // length clamp: only needed when the address space exceeds the depth
   generate
      if (bool_full) begin : g_len_full
         assign len_fix = (len_in == '0) ? START_STEP : len_in;
      end else begin : g_len_clamp
         always_comb begin
            if (len_in == '0)            len_fix = START_STEP;
            else if (len_in > LAST_STEP) len_fix = LAST_STEP;
            else                         len_fix = len_in;
         end
      end
   endgenerate

   always_comb begin
      if (!advance)          act = STEP_HOLD;
      else if (pos >= len_q) act = STEP_WRAP;
      else                   act = STEP_NEXT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos        <= '0;
         len_q      <= LAST_STEP;
         wrap_pulse <= 1'b0;
      end else begin
         if (len_we) len_q <= len_fix;
         wrap_pulse <= (act == STEP_WRAP);
         case (act)
            STEP_NEXT: pos <= pos + 1'b1;
            STEP_WRAP: pos <= START_STEP;
            default:   pos <= pos;
         endcase
      end
   end

endmodule

// File: rtl/seq_step_table.sv
module seq_step_table #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [WORD_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   logic [DEPTH-1:0][WORD_W-1:0] words;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic [WORD_W-1:0] word_q;
         logic              hit_wr;
         logic              hit_ld;

         assign hit_wr = wr_en && (wr_addr == ADDR_W'(e));
         // the write port wins: a capture is dropped whenever a write is present
         assign hit_ld = !wr_en && ld_en && (ld_addr == ADDR_W'(e));

         always_ff @(posedge clk) begin
            if (hit_wr)      word_q <= wr_data;
            else if (hit_ld) word_q <= ld_data;
         end

         assign words[e] = word_q;
      end
   endgenerate

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/seq_mask_merge.sv
module seq_mask_merge #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_en,
   input  logic [WORD_W-1:0] src,
   input  logic [WORD_W-1:0] mask,
   output logic [WORD_W-1:0] q
);

   generate
      for (genvar b = 0; b < WORD_W; b++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (rst)                     bit_q <= 1'b0;
            else if (upd_en && mask[b])  bit_q <= src[b];
         end
         assign q[b] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/seq_masked_compare.sv
module seq_masked_compare #(
   parameter int WORD_W     = 16,
   parameter bit REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [WORD_W-1:0] mask,
   output logic              eq
);

   logic [WORD_W-1:0] diff;
   logic              eq_now;

   assign diff   = (a ^ b) & mask;
   assign eq_now = en && (diff == '0);

   generate
      if (REGISTERED) begin : g_reg
         logic eq_q;
         always_ff @(posedge clk) begin
            if (rst) eq_q <= 1'b0;
            else     eq_q <= eq_now;
         end
         assign eq = eq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst;
         assign eq = eq_now;
      end
   endgenerate

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer #(
   parameter int WORD_W    = 16,
   parameter int DEPTH     = 16,
   parameter bit REG_MATCH = 1'b0,
   localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_cond,
   input  logic              len_we,
   input  logic [ADDR_W-1:0] len_in,
   input  logic              tbl_we,
   input  logic [ADDR_W-1:0] tbl_addr,
   input  logic [WORD_W-1:0] tbl_wdata,
   input  logic              load_req,
   input  logic [WORD_W-1:0] in_image,
   input  logic [WORD_W-1:0] out_mask,
   input  logic [WORD_W-1:0] cmp_mask,
   output logic [WORD_W-1:0] out_word,
   output logic              cmp_match,
   output logic [ADDR_W-1:0] step_pos,
   output logic              done_pulse
);

   // elaboration-time parameter checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("step_sequencer: DEPTH must be at least 2");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("step_sequencer: WORD_W must be at least 1");
      end
   endgenerate

   logic              adv_rise;
   logic              cond_q;
   logic [ADDR_W-1:0] len_q;
   logic [WORD_W-1:0] cur_word;
   logic              pos_live;

   seq_rise_detect #(.IDLE_HIGH(1'b1)) u_rise (
      .clk     (clk),
      .rst     (rst),
      .level   (adv_cond),
      .rise    (adv_rise),
      .level_q (cond_q)
   );

   seq_step_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .advance    (adv_rise),
      .len_we     (len_we),
      .len_in     (len_in),
      .pos        (step_pos),
      .len_q      (len_q),
      .wrap_pulse (done_pulse)
   );

   seq_step_table #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tbl (
      .clk     (clk),
      .wr_en   (tbl_we),
      .wr_addr (tbl_addr),
      .wr_data (tbl_wdata),
      .ld_en   (load_req),
      .ld_addr (step_pos),
      .ld_data (in_image),
      .rd_addr (step_pos),
      .rd_data (cur_word)
   );

   assign pos_live = (step_pos != '0);

   seq_mask_merge #(.WORD_W(WORD_W)) u_out (
      .clk    (clk),
      .rst    (rst),
      .upd_en (pos_live),
      .src    (cur_word),
      .mask   (out_mask),
      .q      (out_word)
   );

   seq_masked_compare #(.WORD_W(WORD_W), .REGISTERED(REG_MATCH)) u_cmp (
      .clk  (clk),
      .rst  (rst),
      .en   (pos_live),
      .a    (in_image),
      .b    (cur_word),
      .mask (cmp_mask),
      .eq   (cmp_match)
   );

endmodule

// File: rtl/step_sequencer_checker.sv
module step_sequencer_checker #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              adv_cond,
   input logic              cond_q,
   input logic [ADDR_W-1:0] step_pos,
   input logic [ADDR_W-1:0] len_q,
   input logic              done_pulse,
   input logic [WORD_W-1:0] out_word,
   input logic              cmp_match
);

   // R2: a held condition never moves the position
   p_hold_no_step_r2: assert property (@(posedge clk) disable iff (rst)
      (adv_cond && cond_q) |=> $stable(step_pos));

   // R2: an advance below the length moves exactly one step
   p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
      (adv_cond && !cond_q && (step_pos < len_q)) |=>
         (step_pos == ADDR_W'($past(step_pos) + 1'b1)));

   // R3: done lasts one cycle only
   p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
      done_pulse |=> !done_pulse);

   // R3: done comes with the position back at step 1
   p_done_at_first_r3: assert property (@(posedge clk) disable iff (rst)
      done_pulse |-> (step_pos == ADDR_W'(1)));

   // R4: step 0 leaves the outputs untouched
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (step_pos == '0) |=> $stable(out_word));

   // R5: no match is reported at step 0
   p_no_match_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (step_pos == '0) |-> !cmp_match);

   // R8: the length register never holds zero
   p_len_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
      len_q != '0);

   // R9: step 0 is never re-entered without reset
   p_no_return_r9: assert property (@(posedge clk) disable iff (rst)
      (step_pos != '0) |=> (step_pos != '0));

endmodule

bind step_sequencer step_sequencer_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .adv_cond   (adv_cond),
   .cond_q     (cond_q),
   .step_pos   (step_pos),
   .len_q      (len_q),
   .done_pulse (done_pulse),
   .out_word   (out_word),
   .cmp_match  (cmp_match)
);

// File: tb/step_sequencer_test.sv
`timescale 1ns/1ps
module step_sequencer_test;

   localparam int W  = 16;
   localparam int D  = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          adv_cond;
   logic          len_we;
   logic [AW-1:0] len_in;
   logic          tbl_we;
   logic [AW-1:0] tbl_addr;
   logic [W-1:0]  tbl_wdata;
   logic          load_req;
   logic [W-1:0]  in_image;
   logic [W-1:0]  out_mask;
   logic [W-1:0]  cmp_mask;
   logic [W-1:0]  out_word;
   logic          cmp_match;
   logic [AW-1:0] step_pos;
   logic          done_pulse;

   always #2.5 clk = ~clk;

   step_sequencer #(.WORD_W(W), .DEPTH(D)) uut (
      .clk(clk), .rst(rst), .adv_cond(adv_cond), .len_we(len_we), .len_in(len_in),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .load_req(load_req),
      .in_image(in_image), .out_mask(out_mask), .cmp_mask(cmp_mask), .out_word(out_word),
      .cmp_match(cmp_match), .step_pos(step_pos), .done_pulse(done_pulse)
   );

   int n_chk  = 0;
   int n_fail = 0;

   logic [W-1:0] tab_m [D];
   logic [W-1:0] model_out;
   int           pm;
   int           lm;

   function automatic logic [W-1:0] pat(int i);
      return W'((i * 16'h2F1D) ^ 16'h5A5A);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_step();
      int nx;
      bit dn;
      dn = (pm >= lm);
      nx = dn ? 1 : pm + 1;
      @(negedge clk) adv_cond = 1'b1;
      @(negedge clk);
      chk("R2 position after advance", step_pos, nx);
      chk("R3 done on advance", done_pulse, dn);
      adv_cond = 1'b0;
      pm = nx;
      model_out = (tab_m[pm] & out_mask) | (model_out & ~out_mask);
      @(negedge clk);
      chk("R3 done one cycle", done_pulse, 0);
      chk("R4 masked output", out_word, model_out);
   endtask

   task automatic set_mask(logic [W-1:0] m);
      @(negedge clk) out_mask = m;
      if (pm != 0) model_out = (tab_m[pm] & m) | (model_out & ~m);
      @(negedge clk);
   endtask

   task automatic set_len(int v);
      @(negedge clk) begin len_we = 1'b1; len_in = AW'(v); end
      @(negedge clk) len_we = 1'b0;
      lm = (v == 0) ? 1 : v;
   endtask

   task automatic apply_reset();
      @(negedge clk) rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 reset position", step_pos, 0);
      chk("R1 reset output", out_word, 0);
      chk("R1 reset done", done_pulse, 0);
      chk("R1 reset match", cmp_match, 0);
      rst = 1'b0;
      pm = 0; lm = D - 1; model_out = '0;
   endtask

   task automatic run_all();
      int p;
      int q;
      rst = 1'b1; adv_cond = 1'b1; len_we = 0; len_in = '0; tbl_we = 0; tbl_addr = '0;
      tbl_wdata = '0; load_req = 0; in_image = '0; out_mask = '0; cmp_mask = '0;
      repeat (3) @(negedge clk);
      apply_reset();
      // condition held high through reset release: no step
      repeat (3) @(negedge clk);
      chk("R1 held condition after reset", step_pos, 0);
      adv_cond = 1'b0;

      for (int i = 0; i < D; i++) begin
         @(negedge clk) begin tbl_we = 1'b1; tbl_addr = AW'(i); tbl_wdata = pat(i); end
         tab_m[i] = pat(i);
      end
      @(negedge clk) tbl_we = 1'b0;
      set_mask(16'hFFFF);
      @(negedge clk);
      chk("R4 output holds at step 0", out_word, 0);

      // full walk with default length, including the wrap
      for (int k = 0; k < D; k++) do_step();

      // held condition: exactly one step
      @(negedge clk) adv_cond = 1'b1;
      @(negedge clk);
      chk("R2 held advance first", step_pos, pm + 1);
      pm = pm + 1;
      repeat (4) begin
         @(negedge clk);
         chk("R2 held no further step", step_pos, pm);
         chk("R3 held no done", done_pulse, 0);
      end
      adv_cond = 1'b0;
      model_out = tab_m[pm];
      @(negedge clk);
      chk("R4 output after hold", out_word, model_out);

      // mask patterns
      foreach (tab_m[i]) begin end
      set_mask(16'h00FF); do_step(); do_step();
      set_mask(16'hF0F0); do_step(); do_step();
      set_mask(16'h0000); do_step();
      set_mask(16'h0001); do_step(); do_step();
      set_mask(16'hFFFF); do_step();

      // masked compare sweep at the current step
      p = pm;
      @(negedge clk) begin cmp_mask = 16'hFFFF; in_image = tab_m[p]; end
      #1 chk("R5 full compare equal", cmp_match, 1);
      for (int b = 0; b < W; b++) begin
         @(negedge clk) begin cmp_mask = 16'hFFFF; in_image = tab_m[p] ^ W'(1 << b); end
         #1 chk("R5 single bit differs", cmp_match, 0);
         @(negedge clk) cmp_mask = ~W'(1 << b);
         #1 chk("R5 differing bit masked off", cmp_match, 1);
      end

      // capture at current step
      @(negedge clk) begin in_image = 16'hBEEF; load_req = 1'b1; end
      @(negedge clk) load_req = 1'b0;
      tab_m[p] = 16'hBEEF;
      model_out = 16'hBEEF;
      @(negedge clk);
      chk("R6 captured word drives output", out_word, 16'hBEEF);
      cmp_mask = 16'hFFFF;
      #1 chk("R6 captured word matches", cmp_match, 1);

      // write and capture together: write wins, capture dropped
      q = (pm >= lm) ? 1 : pm + 1;
      @(negedge clk) begin
         in_image = 16'h1234; load_req = 1'b1;
         tbl_we = 1'b1; tbl_addr = AW'(q); tbl_wdata = 16'h0F0F;
      end
      @(negedge clk) begin load_req = 1'b0; tbl_we = 1'b0; end
      tab_m[q] = 16'h0F0F;
      @(negedge clk);
      chk("R7 capture dropped under write", out_word, 16'hBEEF);
      #1 chk("R7 reference unchanged", cmp_match, 0);
      do_step();
      chk("R7 written entry reached", out_word, 16'h0F0F);

      // length register
      set_len(3);
      repeat (5) do_step();
      set_len(0);
      repeat (3) begin
         do_step();
         chk("R8 zero length stored as one", step_pos, 1);
      end
      set_len(5);
      repeat (7) do_step();
      chk("R9 position nonzero", step_pos != 0, 1);

      // reset mid-run restores default length
      apply_reset();
      adv_cond = 1'b0;
      for (int k = 0; k < D; k++) do_step();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule